// File: doc/BRIEF.md
# Request-Triggered Byte/Word DMA Channel

This block is a single DMA channel. It copies data between a 12-bit addressed register file and one peripheral register that sits in a fixed top page of the same address space. Software programs a start address, an end address, a peripheral offset and a control byte. After that, each rising edge on the selected trigger input moves one unit. A unit is one byte or one two-byte word. The register-file pointer steps forward after each unit. When the unit that touches the end address completes, the pointer returns to the start. The channel then either keeps running or switches itself off, and it may raise a one-cycle interrupt.

All traffic uses a simple request/grant bus. The channel holds `bus_req` with a stable address and direction until it sees `bus_gnt`. Every byte costs one read access followed by one write access. Read data is taken in the cycle the read is granted.

Top module: `dma_channel`

## Requirements
- R1: While control bit 0 (enable) is 0, trigger edges are not recorded and cause no bus access.
- R2: With control bit 1 (loop) at 0, the unit that moves the byte at the end address resets the pointer to the start address and clears the enable bit, so that `chan_en` reads 0.
- R3: With loop at 1, the same event resets the pointer to the start address, and the channel stays enabled for later triggers.
- R4: With control bit 2 (direction) at 0, bytes go from the register file to the peripheral register. With it at 1, bytes go from the peripheral register into the register file.
- R5: With control bit 3 (interrupt enable) at 1, `irq` is high for exactly one cycle after a unit that moved the end-address byte. With it at 0, `irq` stays low.
- R6: With control bit 4 (word) at 0, a trigger moves one byte and the pointer advances by 1. With it at 1, a trigger moves bytes at pointer and pointer+1 to or from peripheral offsets p and p+1, and the pointer advances by 2. A word unit that touches the end address on either byte counts as reaching the end.
- R7: In word mode, if the peripheral offset is odd, a trigger produces a one-cycle `err` pulse and no bus access.
- R8: Control bits 7:5 select the trigger input: code k (0 to 6) selects `trig_in[k]`, where 0 to 3 are timers, 4 is UART0, 5 is UART1 and 6 is I2C. Code 7 never triggers. Edges on inputs that are not selected have no effect.
- R9: Every peripheral-side access uses address {4'hF, offset}.
- R10: A trigger edge is held as pending. One edge arriving during a unit is serviced after that unit ends. Any further edges during that unit are dropped.
- R11: Each byte is a read access, then a write access. An access stays requested, with stable address and direction, until it is granted.
- R12: Configuration is selected by `cfg_sel`: 0 is control, 1 is start, 2 is end, 3 is peripheral offset. Writes are accepted at any time. A control write with bit 0 set reloads the pointer from the start address.
- R13: After reset the channel is disabled, and `bus_req`, `irq` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write data |
| trig_in | input | 7 | Trigger request inputs, one per source code |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 12 | Bus access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with grant |
| bus_gnt | input | 1 | Access grant |
| irq | output | 1 | End-of-block interrupt pulse |
| err | output | 1 | Odd-offset word request pulse |
| chan_en | output | 1 | Current value of the enable bit |

## Verification
A wrong pointer or a wrong end comparison appears on `bus_addr` in the first access of the next unit. The same fault shows up one cycle later as a wrong `irq` or `chan_en` at the end of the block. A stuck pending flag shows up as an extra or missing unit within a few cycles of the trigger edge. A corrupted latched direction or offset shows up as a wrong byte in memory within the unit where it happens. The bench therefore compares the whole memory image, the final enable state and the interrupt and error counts with an independent model after every sequence.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel.
// Assumes the control byte layout given here is the one software uses.
package dma_chan_pkg;

    localparam int TRIG_SEL_W = 3;

    // Configuration register selector values.
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_START  = 2'd1,
        SEL_END    = 2'd2,
        SEL_PERIPH = 2'd3
    } cfg_sel_t;

    // Control byte, bit 0 is the enable bit.
    typedef struct packed {
        logic [TRIG_SEL_W-1:0] trig_sel;
        logic                  word;
        logic                  irq_en;
        logic                  dir;
        logic                  loop;
        logic                  en;
    } ctrl_t;

    // Transfer sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/dma_trig_pick.sv
// Picks one trigger input by code, detects its rising edge and keeps one
// pending request. Assumes trigger inputs are synchronous to clk.
// Codes at or beyond NTRIG select nothing.
module dma_trig_pick #(
    parameter int NTRIG = 7,
    parameter int SELW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [SELW-1:0]  sel,
    input  logic             enable,
    input  logic             take,
    output logic             pending
);

    logic lvl;
    logic lvl_prev;
    logic rise;

    // Select the level of the chosen trigger input.
    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (sel == SELW'(i)) lvl = trig_in[i];
        end
    end

    assign rise = lvl && !lvl_prev;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    // Single pending slot: set by an edge, cleared when a unit starts.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (!enable) pending <= 1'b0;
        else if (rise)    pending <= 1'b1;
        else if (take)    pending <= 1'b0;
    end

    assert_no_pending_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pending);

endmodule

// File: rtl/dma_addr_track.sv
// Holds the register-file pointer. Reloads it on a start request and steps
// it or wraps it to the start address when a unit completes.
// Assumes load and advance are single-cycle strobes.
module dma_addr_track #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic          advance,
    input  logic          wrap,
    input  logic          word,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] step;

    assign step = word ? AW'(2) : AW'(1);

    // Pointer update; a configuration reload wins over unit completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_addr <= '0;
        else if (load)    cur_addr <= start_addr;
        else if (advance) cur_addr <= wrap ? start_addr : cur_addr + step;
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
// Runs one transfer unit: one or two bytes, each a read followed by a write
// on the request/grant bus. It copies the pointer, offset, direction and
// size at unit start, so configuration writes cannot disturb a running
// unit. Read data is assumed valid in the cycle the read is granted.
module dma_xfer_fsm
    import dma_chan_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic          enable,
    input  logic          word,
    input  logic          dir,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [PW-1:0] periph_lo,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          take,
    output logic          unit_done,
    output logic          end_hit,
    output logic          unit_word,
    output logic          err
);

    localparam logic [AW-PW-1:0] PAGE = '1;

    xfer_state_t   state;
    logic [AW-1:0] rf_base;
    logic [PW-1:0] p_base;
    logic          u_dir;
    logic          idx;
    logic          hit_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] rf_addr;
    logic [AW-1:0] pa_addr;
    logic [PW-1:0] p_lo;
    logic          last;
    logic          hit_now;

    assign rf_addr   = rf_base + AW'(idx);
    assign p_lo      = p_base + PW'(idx);
    assign pa_addr   = {PAGE, p_lo};
    assign last      = !unit_word || idx;
    assign hit_now   = hit_q || (rf_addr == end_addr);

    assign take      = (state == ST_IDLE) && pending && enable;
    assign unit_done = (state == ST_WR) && bus_gnt && last;
    assign end_hit   = hit_now;

    assign bus_req   = (state != ST_IDLE);
    assign bus_we    = (state == ST_WR);
    assign bus_addr  = (bus_we ^ u_dir) ? pa_addr : rf_addr;
    assign bus_wdata = data_q;

    // Sequence the read and write accesses of each byte in a unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rf_base   <= '0;
            p_base    <= '0;
            u_dir     <= 1'b0;
            unit_word <= 1'b0;
            idx       <= 1'b0;
            hit_q     <= 1'b0;
            data_q    <= '0;
            err       <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        if (word && periph_lo[0]) begin
                            err <= 1'b1;
                        end else begin
                            rf_base   <= cur_addr;
                            p_base    <= periph_lo;
                            u_dir     <= dir;
                            unit_word <= word;
                            idx       <= 1'b0;
                            hit_q     <= 1'b0;
                            state     <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (bus_gnt) begin
                        data_q <= bus_rdata;
                        state  <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (bus_gnt) begin
                        hit_q <= hit_now;
                        if (last) begin
                            state <= ST_IDLE;
                        end else begin
                            idx   <= 1'b1;
                            state <= ST_RD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && !bus_we |=> bus_req && bus_we);

    assert_periph_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (u_dir != bus_we) |-> (&bus_addr[AW-1:PW]));

    assert_even_word_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && unit_word |-> !p_base[0]);

    assert_err_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_req);

endmodule

// File: rtl/dma_channel.sv
// One DMA channel: the configuration registers, trigger selection, the
// register-file pointer and the transfer sequencer. Assumes one bus master
// per bus and synchronous triggers. Control writes may happen at any time.
module dma_channel
    import dma_chan_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int PW    = 8,
    parameter int NTRIG = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic [NTRIG-1:0] trig_in,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_gnt,
    output logic             irq,
    output logic             err,
    output logic             chan_en
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl;
    logic [AW-1:0] start_q;
    logic [AW-1:0] end_q;
    logic [PW-1:0] periph_q;
    logic [AW-1:0] cur_addr;
    logic          wr_ctrl;
    logic          load_start;
    logic          pending;
    logic          take;
    logic          unit_done;
    logic          end_hit;
    logic          unit_word;

    assign wr_ctrl    = cfg_we && (cfg_sel == SEL_CTRL);
    assign load_start = wr_ctrl && cfg_wdata[0];
    assign chan_en    = ctrl.en;

    // Control register; hardware clears enable at the end of a one-shot block.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ctrl <= '0;
        else if (wr_ctrl)                            ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        else if (unit_done && end_hit && !ctrl.loop) ctrl.en <= 1'b0;
    end

    // Address configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            end_q    <= '0;
            periph_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_START)  start_q  <= cfg_wdata;
            if (cfg_sel == SEL_END)    end_q    <= cfg_wdata;
            if (cfg_sel == SEL_PERIPH) periph_q <= cfg_wdata[PW-1:0];
        end
    end

    // One-cycle interrupt after the end-address unit.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= unit_done && end_hit && ctrl.irq_en;
    end

    dma_trig_pick #(
        .NTRIG (NTRIG),
        .SELW  (TRIG_SEL_W)
    ) i_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (ctrl.trig_sel),
        .enable  (ctrl.en),
        .take    (take),
        .pending (pending)
    );

    dma_addr_track #(
        .AW (AW)
    ) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_start),
        .start_addr (start_q),
        .advance    (unit_done),
        .wrap       (end_hit),
        .word       (unit_word),
        .cur_addr   (cur_addr)
    );

    dma_xfer_fsm #(
        .AW (AW),
        .DW (DW),
        .PW (PW)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .enable    (ctrl.en),
        .word      (ctrl.word),
        .dir       (ctrl.dir),
        .cur_addr  (cur_addr),
        .end_addr  (end_q),
        .periph_lo (periph_q),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .take      (take),
        .unit_done (unit_done),
        .end_hit   (end_hit),
        .unit_word (unit_word),
        .err       (err)
    );

    assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_oneshot_disables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done && end_hit && !ctrl.loop && !wr_ctrl |=> !chan_en);

    assert_loop_stays_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done && ctrl.loop && ctrl.en && !cfg_we |=> chan_en);

endmodule

// File: tb/test_dma_channel.sv
module test_dma_channel;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  sel;
        logic        word;
        logic        irq_en;
        logic        dir;
        logic        loop;
        logic [11:0] start;
        logic [11:0] stop;
        logic [7:0]  periph;
        logic [3:0]  nreq;
        logic [1:0]  stall;
        logic        exp_en;
        logic [3:0]  exp_irq;
        logic [3:0]  exp_err;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h010, 12'h012, 8'h20, 4'd3, 2'd0, 1'b0, 4'd1, 4'd0},
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h100, 12'h103, 8'h40, 4'd4, 2'd1, 1'b1, 4'd2, 4'd0},
        '{3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 12'h200, 12'h201, 8'h41, 4'd2, 2'd2, 1'b1, 4'd0, 4'd2},
        '{3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 12'h300, 12'h300, 8'h50, 4'd1, 2'd0, 1'b1, 4'd0, 4'd0},
        '{3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 12'h050, 12'h051, 8'hFE, 4'd3, 2'd1, 1'b0, 4'd0, 4'd0},
        '{3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 12'h0A0, 12'h0A2, 8'h10, 4'd2, 2'd2, 1'b0, 4'd1, 4'd0},
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 12'h0FF, 12'h0FF, 8'h33, 4'd2, 2'd0, 1'b1, 4'd0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [11:0] cfg_wdata = '0;
    logic [6:0]  trig_in = '0;
    logic        bus_req, bus_we, bus_gnt, irq, err, chan_en;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;

    logic [7:0] mem [0:4095];
    logic [7:0] expm [0:4095];
    int stall = 0;
    int gcnt = 0;
    int irq_cnt = 0, err_cnt = 0;
    int order_bad = 0, wr_seen = 0;
    logic rd_open = 1'b0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [11:0] m_cur, m_start, m_end;
    logic [7:0]  m_periph;
    logic [2:0]  m_sel;
    logic        m_en, m_loop, m_dir, m_word, m_irqe;
    int          m_irqs, m_errs;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_channel i_dma_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .trig_in   (trig_in),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_gnt   (bus_gnt),
        .irq       (irq),
        .err       (err),
        .chan_en   (chan_en)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 13 + 5);
    endfunction

    assign bus_rdata = mem[bus_addr];

    // Bus responder, memory and event counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
            bus_gnt <= 1'b0;
            gcnt    <= 0;
            irq_cnt <= 0;
            err_cnt <= 0;
            rd_open <= 1'b0;
        end else begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (err) err_cnt <= err_cnt + 1;
            if (bus_req && bus_gnt) begin
                if (bus_we) begin
                    mem[bus_addr] <= bus_wdata;
                    wr_seen <= wr_seen + 1;
                    if (!rd_open) order_bad <= order_bad + 1;
                    rd_open <= 1'b0;
                end else begin
                    if (rd_open) order_bad <= order_bad + 1;
                    rd_open <= 1'b1;
                end
            end
            if (bus_req && !bus_gnt) begin
                if (gcnt >= stall) begin
                    bus_gnt <= 1'b1;
                    gcnt    <= 0;
                end else begin
                    gcnt <= gcnt + 1;
                end
            end else begin
                bus_gnt <= 1'b0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Reference model of one trigger on input code.
    task automatic model_req(input int code);
        logic [11:0] rf, pa;
        bit hit;
        int n;
        if (!m_en || m_sel == 3'd7 || code != int'(m_sel)) return;
        if (m_word && m_periph[0]) begin
            m_errs++;
            return;
        end
        n = m_word ? 2 : 1;
        hit = 1'b0;
        for (int k = 0; k < n; k++) begin
            rf = m_cur + 12'(k);
            pa = {4'hF, 8'(m_periph + 8'(k))};
            if (m_dir) expm[rf] = expm[pa];
            else       expm[pa] = expm[rf];
            if (rf == m_end) hit = 1'b1;
        end
        if (hit) begin
            m_cur = m_start;
            if (m_irqe) m_irqs++;
            if (!m_loop) m_en = 1'b0;
        end else begin
            m_cur = m_cur + 12'(n);
        end
    endtask

    task automatic fire(input int code);
        @(negedge clk); trig_in[code] = 1'b1;
        @(negedge clk); trig_in[code] = 1'b0;
        repeat (60) @(negedge clk);
        model_req(code);
    endtask

    task automatic setup(input logic [2:0] sel, input logic word, input logic irqe,
                         input logic dir, input logic loop, input logic en,
                         input logic [11:0] st, input logic [11:0] sp,
                         input logic [7:0] pr, input int stl);
        stall = stl;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4096; i++) expm[i] = pat(i);
        m_sel = sel; m_word = word; m_irqe = irqe; m_dir = dir; m_loop = loop;
        m_en = en; m_start = st; m_end = sp; m_periph = pr;
        m_irqs = 0; m_errs = 0; m_cur = 12'h000;
        cfg_write(2'd1, st);
        cfg_write(2'd2, sp);
        cfg_write(2'd3, {4'h0, pr});
        cfg_write(2'd0, {4'h0, sel, word, irqe, dir, loop, en});
        if (en) m_cur = st;
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) d++;
        return d;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R13: reset state
        repeat (3) @(negedge clk);
        chk("R13 bus_req after reset", int'(bus_req), 0);
        chk("R13 chan_en after reset", int'(chan_en), 0);
        chk("R13 irq/err after reset", int'(irq | err), 0);

        // Table of vectors
        for (int v = 0; v < NVEC; v++) begin
            setup(VECS[v].sel, VECS[v].word, VECS[v].irq_en, VECS[v].dir, VECS[v].loop,
                  1'b1, VECS[v].start, VECS[v].stop, VECS[v].periph, int'(VECS[v].stall));
            if (VECS[v].sel != 3'd7) fire((int'(VECS[v].sel) + 1) % 7); // R8 other source
            for (int r = 0; r < int'(VECS[v].nreq); r++) begin
                if (VECS[v].sel == 3'd7) begin
                    for (int c = 0; c < 7; c++) fire(c);                  // R8 reserved code
                end else begin
                    fire(int'(VECS[v].sel));
                end
            end
            chk($sformatf("R4 R6 R9 memory image, vector %0d", v), mem_diff(), 0);
            chk($sformatf("R2 R3 enable state, vector %0d", v), int'(chan_en), int'(VECS[v].exp_en));
            chk($sformatf("R5 irq pulses, vector %0d", v), irq_cnt, int'(VECS[v].exp_irq));
            chk($sformatf("R7 err pulses, vector %0d", v), err_cnt, int'(VECS[v].exp_err));
            chk($sformatf("model agrees with table, vector %0d", v), m_irqs + 16 * m_errs,
                int'(VECS[v].exp_irq) + 16 * int'(VECS[v].exp_err));
        end

        // R1: disabled channel ignores triggers
        setup(3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h600, 12'h600, 8'h80, 0);
        fire(0);
        fire(0);
        chk("R1 memory untouched while disabled", mem_diff(), 0);
        chk("R1 no irq while disabled", irq_cnt, 0);

        // R10: one held edge, further edges dropped
        setup(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h400, 12'h4FF, 8'h60, 3);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); trig_in[2] = 1'b1;
            @(negedge clk); trig_in[2] = 1'b0;
        end
        repeat (80) @(negedge clk);
        model_req(2);
        model_req(2);
        chk("R10 two units from three close edges", mem_diff(), 0);
        chk("R10 third edge dropped", int'(mem[12'h402]), int'(pat(12'h402)));

        // R12: control write with enable reloads the pointer
        setup(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h500, 12'h5FF, 8'h70, 0);
        fire(0);
        fire(0);
        cfg_write(2'd0, {4'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        m_cur = m_start;
        fire(0);
        chk("R12 reload restarts at start address", int'(mem[12'hF70]), int'(pat(12'h500)));
        chk("R12 memory image after reload", mem_diff(), 0);

        // R11: bus ordering over the whole run
        chk("R11 read-before-write order violations", order_bad, 0);
        chk("R11 granted writes observed", int'(wr_seen > 0), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule